// File: doc/BRIEF.md
# Accumulator Add/Subtract Unit with Condition Flags

This block holds a pair of 8-bit accumulators and an 8-bit condition register. It performs add and subtract on them, with and without carry. Each arithmetic operation adds or subtracts the second accumulator to or from the first, and writes the result back into the first. The two accumulators can also be read as one 16-bit word, with the first accumulator as the upper byte. Arithmetic can update the negative, zero, overflow, carry and half-carry flags. A flag-update enable can suppress that update. The three control bits of the condition register are stored and written, but no logic acts on them.

A branch evaluator reads the stored flags and reports whether a selected branch condition is met. A sequencer places a branch after a flag-setting operation in order to decide whether to take it. Every operation takes effect on the clock edge at which `op_valid` is high. The branch output is combinational from the stored flags, so it reflects the outcome of an operation in the cycle after that edge.

The register state uses one process for the registers and one for the next-state values, with named operation and branch encodings from a shared package.

Top module: `acc_cc_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released, accumulator A and accumulator B read 0x00 and the condition register reads 0xD0. The condition register layout is bit 7 stop-disable, bit 6 pseudo-NMI mask, bit 5 half-carry H, bit 4 interrupt mask, bit 3 N, bit 2 Z, bit 1 V, bit 0 C.
- R2: `acc_d` always equals {A, B}, with A in bits 15:8.
- R3: Op code 1 loads `din` into A and op code 2 loads `din` into B. Neither load changes the condition register, and arithmetic never changes B.
- R4: Op code 3 (add) writes A+B to A. With updates enabled, it sets the flags as follows. C is the carry out of bit 7. V is set when both operands have the same sign and the result sign differs. H is the carry from bit 3 into bit 4. N is result bit 7. Z is set only when the result is zero. For example, 0x93 + 0xB3 gives 0x46 with C=1 and V=1.
- R5: Op code 5 (subtract) writes A-B to A. With updates enabled, C is set when a borrow is needed. V is set when the operands have opposite signs and the result sign differs from A. N and Z follow R4, and H is unchanged. For example, 0x93 - 0xB3 gives 0xE0 with C=1, V=0 and N=1.
- R6: Op code 4 (add with carry) and op code 6 (subtract with borrow) use the stored C as carry-in or borrow-in. Their flags follow R4 and R5 respectively.
- R7: An arithmetic operation with `upd_flags` low still writes A, but leaves all eight condition bits unchanged.
- R8: Op code 7 writes `din` into all eight condition bits, whatever the value of `upd_flags`. Bits 7, 6 and 4 change only through this operation.
- R9: `br_taken` reflects the stored flags for the `br_sel` codes as follows.
  - 0: C=1
  - 1: C=0
  - 2: Z=0
  - 3: Z=1
  - 4: C=0 and Z=0
  - 5: C=1 or Z=1
  - 6: N=1
  - 7: V=1
- R10: With `op_valid` low, or with op code 0 or 8 to 15, nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Apply `op_sel` on this edge |
| op_sel | input | 4 | Operation code |
| upd_flags | input | 1 | Arithmetic may update flags |
| din | input | 8 | Load data for A, B or condition register |
| br_sel | input | 3 | Branch condition select |
| acc_a | output | 8 | Accumulator A |
| acc_b | output | 8 | Accumulator B |
| acc_d | output | 16 | A and B as one word |
| ccr | output | 8 | Condition register |
| br_taken | output | 1 | Selected condition is met |

## Verification
A wrong flag appears on `ccr` one cycle after the operation that produced it. Through `br_taken`, it also misdirects the next branch, in the same cycle. A wrong stored carry stays hidden until a carry-in operation uses it, and it then corrupts A one cycle later. For this reason, carry chains are checked across consecutive operations. Corrupted control bits persist until the next explicit condition write. They are therefore compared after every operation, not only after writes.

// File: rtl/acc_cc_pkg.sv
package acc_cc_pkg;

    localparam int CC_W = 8;
    localparam int CCB_C = 0;
    localparam int CCB_V = 1;
    localparam int CCB_Z = 2;
    localparam int CCB_N = 3;
    localparam int CCB_I = 4;
    localparam int CCB_H = 5;
    localparam int CCB_X = 6;
    localparam int CCB_S = 7;
    localparam logic [CC_W-1:0] CC_RST = 8'hD0;

    typedef enum logic [3:0] {
        OP_NOP = 4'd0,
        OP_LDA = 4'd1,
        OP_LDB = 4'd2,
        OP_ADD = 4'd3,
        OP_ADC = 4'd4,
        OP_SUB = 4'd5,
        OP_SBC = 4'd6,
        OP_CCW = 4'd7
    } op_e;

    typedef enum logic [2:0] {
        BR_CS = 3'd0,
        BR_CC = 3'd1,
        BR_NE = 3'd2,
        BR_EQ = 3'd3,
        BR_HI = 3'd4,
        BR_LS = 3'd5,
        BR_MI = 3'd6,
        BR_VS = 3'd7
    } br_e;

endpackage

// File: rtl/acc_addsub.sv
module acc_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         c_out,
    output logic         v_out,
    output logic         h_out
);
    localparam int MSB = W - 1;
    localparam int HB  = 4;

    logic [W:0]  ext;
    logic [HB:0] low;

    always_comb begin
        if (sub) begin
            ext = {1'b0, opa} - {1'b0, opb} - {{W{1'b0}}, cin};
        end else begin
            ext = {1'b0, opa} + {1'b0, opb} + {{W{1'b0}}, cin};
        end
        low   = {1'b0, opa[HB-1:0]} + {1'b0, opb[HB-1:0]} + {{HB{1'b0}}, cin};
        res   = ext[W-1:0];
        c_out = ext[W];
        h_out = low[HB];
        if (sub) begin
            v_out = (opa[MSB] != opb[MSB]) && (ext[MSB] != opa[MSB]);
        end else begin
            v_out = (opa[MSB] == opb[MSB]) && (ext[MSB] != opa[MSB]);
        end
    end

endmodule

// File: rtl/cc_branch_eval.sv
module cc_branch_eval
    import acc_cc_pkg::*;
(
    input  logic [CC_W-1:0] cc,
    input  logic [2:0]      sel,
    output logic            taken
);
    always_comb begin
        unique case (br_e'(sel))
            BR_CS:   taken = cc[CCB_C];
            BR_CC:   taken = !cc[CCB_C];
            BR_NE:   taken = !cc[CCB_Z];
            BR_EQ:   taken = cc[CCB_Z];
            BR_HI:   taken = !cc[CCB_C] && !cc[CCB_Z];
            BR_LS:   taken = cc[CCB_C] || cc[CCB_Z];
            BR_MI:   taken = cc[CCB_N];
            BR_VS:   taken = cc[CCB_V];
            default: taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/acc_cc_unit.sv
module acc_cc_unit
    import acc_cc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [3:0]       op_sel,
    input  logic             upd_flags,
    input  logic [W-1:0]     din,
    input  logic [2:0]       br_sel,
    output logic [W-1:0]     acc_a,
    output logic [W-1:0]     acc_b,
    output logic [2*W-1:0]   acc_d,
    output logic [CC_W-1:0]  ccr,
    output logic             br_taken
);
    localparam int MSB = W - 1;

    op_e             op;
    logic [W-1:0]    a_q, a_n, b_q, b_n;
    logic [CC_W-1:0] cc_q, cc_n;
    logic            is_sub, use_c, alu_cin;
    logic [W-1:0]    alu_res;
    logic            alu_c, alu_v, alu_h;

    assign op      = op_e'(op_sel);
    assign is_sub  = (op == OP_SUB) || (op == OP_SBC);
    assign use_c   = (op == OP_ADC) || (op == OP_SBC);
    assign alu_cin = use_c & cc_q[CCB_C];

    acc_addsub #(.W(W)) u_alu (
        .opa   (a_q),
        .opb   (b_q),
        .cin   (alu_cin),
        .sub   (is_sub),
        .res   (alu_res),
        .c_out (alu_c),
        .v_out (alu_v),
        .h_out (alu_h)
    );

    cc_branch_eval u_br (
        .cc    (cc_q),
        .sel   (br_sel),
        .taken (br_taken)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q  <= '0;
            b_q  <= '0;
            cc_q <= CC_RST;
        end else begin
            a_q  <= a_n;
            b_q  <= b_n;
            cc_q <= cc_n;
        end
    end

    always_comb begin
        a_n  = a_q;
        b_n  = b_q;
        cc_n = cc_q;
        if (op_valid) begin
            unique case (op)
                OP_LDA: a_n = din;
                OP_LDB: b_n = din;
                OP_CCW: cc_n = din[CC_W-1:0];
                OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
                    a_n = alu_res;
                    if (upd_flags) begin
                        cc_n[CCB_N] = alu_res[MSB];
                        cc_n[CCB_Z] = (alu_res == '0);
                        cc_n[CCB_V] = alu_v;
                        cc_n[CCB_C] = alu_c;
                        if (!is_sub) begin
                            cc_n[CCB_H] = alu_h;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign acc_a = a_q;
    assign acc_b = b_q;
    assign acc_d = {a_q, b_q};
    assign ccr   = cc_q;

endmodule

// File: rtl/acc_cc_chk.sv
module acc_cc_chk
    import acc_cc_pkg::*;
#(
    parameter int W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            op_valid,
    input logic [3:0]      op_sel,
    input logic            upd_flags,
    input logic [2:0]      br_sel,
    input logic [W-1:0]    acc_a,
    input logic [W-1:0]    acc_b,
    input logic [CC_W-1:0] ccr,
    input logic            br_taken
);
    logic arith, subop, ccw;
    assign arith = op_valid && (op_sel >= 4'd3) && (op_sel <= 4'd6);
    assign subop = op_valid && ((op_sel == 4'd5) || (op_sel == 4'd6));
    assign ccw   = op_valid && (op_sel == 4'd7);

    assert_flags_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (arith && !upd_flags) |=> ccr == $past(ccr));

    assert_ctrl_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ccw |=> (ccr[CCB_S] == $past(ccr[CCB_S])) && (ccr[CCB_X] == $past(ccr[CCB_X]))
                 && (ccr[CCB_I] == $past(ccr[CCB_I])));

    assert_nz_track_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (arith && upd_flags) |=> (ccr[CCB_N] == acc_a[W-1]) && (ccr[CCB_Z] == (acc_a == '0)));

    assert_h_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (subop && upd_flags) |=> ccr[CCB_H] == $past(ccr[CCB_H]));

    assert_b_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        arith |=> acc_b == $past(acc_b));

    assert_ne_branch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (br_sel == 3'd2) |-> br_taken == !ccr[CCB_Z]);

    assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (acc_a == $past(acc_a)) && (acc_b == $past(acc_b)) && (ccr == $past(ccr)));

endmodule

bind acc_cc_unit acc_cc_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_sel    (op_sel),
    .upd_flags (upd_flags),
    .br_sel    (br_sel),
    .acc_a     (acc_a),
    .acc_b     (acc_b),
    .ccr       (ccr),
    .br_taken  (br_taken)
);

// File: tb/sim_acc_cc_unit.sv
module sim_acc_cc_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_sel = 4'd0;
    logic        upd_flags = 1'b0;
    logic [7:0]  din = 8'd0;
    logic [2:0]  br_sel = 3'd0;
    logic [7:0]  acc_a, acc_b, ccr;
    logic [15:0] acc_d;
    logic        br_taken;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic [7:0] a;
        logic [7:0] b;
        logic [7:0] cc;
        logic       tk;
    } exp_t;

    exp_t  expq[$];
    string tagq[$];

    logic [7:0] ea = 8'h00, eb = 8'h00, ecc = 8'hD0;

    always #10 clk = ~clk;

    acc_cc_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .upd_flags(upd_flags), .din(din), .br_sel(br_sel), .acc_a(acc_a),
        .acc_b(acc_b), .acc_d(acc_d), .ccr(ccr), .br_taken(br_taken)
    );

    function automatic logic br_model(input logic [7:0] cc, input logic [2:0] bs);
        case (bs)
            3'd0: return cc[0];
            3'd1: return !cc[0];
            3'd2: return !cc[2];
            3'd3: return cc[2];
            3'd4: return !cc[0] && !cc[2];
            3'd5: return cc[0] || cc[2];
            3'd6: return cc[3];
            default: return cc[1];
        endcase
    endfunction

    function automatic int sval(input logic [7:0] x);
        return (x > 8'd127) ? int'(x) - 256 : int'(x);
    endfunction

    task automatic apply(input logic v, input logic [3:0] op, input logic u,
                         input logic [7:0] d, input logic [2:0] bs, input string tag);
        int s, sg, ci;
        logic [7:0] r;
        logic h;
        @(negedge clk);
        op_valid = v; op_sel = op; upd_flags = u; din = d; br_sel = bs;
        if (v) begin
            ci = ((op == 4'd4) || (op == 4'd6)) ? int'(ecc[0]) : 0;
            case (op)
                4'd1: ea = d;
                4'd2: eb = d;
                4'd7: ecc = d;
                4'd3, 4'd4: begin
                    s  = int'(ea) + int'(eb) + ci;
                    sg = sval(ea) + sval(eb) + ci;
                    r  = s[7:0];
                    h  = (int'(ea % 16) + int'(eb % 16) + ci) > 15;
                    if (u) begin
                        ecc[3] = r[7]; ecc[2] = (r == 8'd0);
                        ecc[1] = (sg > 127) || (sg < -128);
                        ecc[0] = s > 255; ecc[5] = h;
                    end
                    ea = r;
                end
                4'd5, 4'd6: begin
                    s  = int'(ea) - int'(eb) - ci;
                    sg = sval(ea) - sval(eb) - ci;
                    r  = s[7:0];
                    if (u) begin
                        ecc[3] = r[7]; ecc[2] = (r == 8'd0);
                        ecc[1] = (sg > 127) || (sg < -128);
                        ecc[0] = s < 0;
                    end
                    ea = r;
                end
                default: ;
            endcase
        end
        expq.push_back('{a: ea, b: eb, cc: ecc, tk: br_model(ecc, bs)});
        tagq.push_back(tag);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (expq.size() > 0) begin
                exp_t e;
                string t;
                e = expq.pop_front();
                t = tagq.pop_front();
                vectors++;
                if (acc_a !== e.a || acc_b !== e.b || acc_d !== {e.a, e.b}
                    || ccr !== e.cc || br_taken !== e.tk) begin
                    fails++;
                    $display("FAIL %s: a=%h b=%h d=%h cc=%h tk=%b expected a=%h b=%h d=%h cc=%h tk=%b",
                             t, acc_a, acc_b, acc_d, ccr, br_taken,
                             e.a, e.b, {e.a, e.b}, e.cc, e.tk);
                end
            end
        end
    end

    initial begin
        #4000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        vectors++;
        if (acc_a !== 8'h00 || acc_b !== 8'h00 || ccr !== 8'hD0 || acc_d !== 16'h0000) begin
            fails++;
            $display("FAIL R1 reset: a=%h b=%h cc=%h expected a=00 b=00 cc=d0", acc_a, acc_b, ccr);
        end
        rst_n = 1'b1;
        // R3 loads, R2 word view
        apply(1, 4'd1, 1, 8'h93, 3'd0, "R3 load A");
        apply(1, 4'd2, 1, 8'hB3, 3'd0, "R2/R3 load B");
        // R4 signed overflow example
        apply(1, 4'd3, 1, 8'h00, 3'd0, "R4 add 93+b3");
        apply(1, 4'd1, 1, 8'h93, 3'd7, "R3 reload A");
        // R5 borrow example
        apply(1, 4'd5, 1, 8'h00, 3'd4, "R5 sub 93-b3");
        // R4 half carry, R5 H unchanged
        apply(1, 4'd1, 1, 8'h0F, 3'd6, "R3 load A");
        apply(1, 4'd2, 1, 8'h01, 3'd6, "R3 load B");
        apply(1, 4'd3, 1, 8'h00, 3'd6, "R4 half carry");
        apply(1, 4'd5, 1, 8'h00, 3'd3, "R5 H kept");
        // R6 carry chain
        apply(1, 4'd1, 1, 8'hFF, 3'd2, "R3 load A");
        apply(1, 4'd3, 1, 8'h00, 3'd2, "R4 wrap to zero");
        apply(1, 4'd1, 1, 8'h10, 3'd5, "R3 load A");
        apply(1, 4'd2, 1, 8'h20, 3'd5, "R3 load B");
        apply(1, 4'd4, 1, 8'h00, 3'd1, "R6 add with carry");
        apply(1, 4'd1, 1, 8'h00, 3'd0, "R3 load A");
        apply(1, 4'd2, 1, 8'h01, 3'd0, "R3 load B");
        apply(1, 4'd5, 1, 8'h00, 3'd0, "R5 borrow");
        apply(1, 4'd1, 1, 8'h05, 3'd0, "R3 load A");
        apply(1, 4'd2, 1, 8'h02, 3'd0, "R3 load B");
        apply(1, 4'd6, 1, 8'h00, 3'd0, "R6 sub with borrow");
        // R7 flags frozen
        apply(1, 4'd1, 1, 8'h7F, 3'd7, "R3 load A");
        apply(1, 4'd2, 1, 8'h01, 3'd7, "R3 load B");
        apply(1, 4'd3, 0, 8'h00, 3'd7, "R7 add no flags");
        apply(1, 4'd5, 0, 8'h00, 3'd3, "R7 sub no flags");
        // R8 condition write and held control bits
        apply(1, 4'd7, 0, 8'h00, 3'd3, "R8 ccr write 00");
        apply(1, 4'd3, 1, 8'h00, 3'd3, "R8 arith keeps S X I");
        apply(1, 4'd7, 1, 8'hD0, 3'd3, "R8 ccr write d0");
        apply(1, 4'd1, 1, 8'h80, 3'd3, "R3 load A");
        apply(1, 4'd2, 1, 8'h80, 3'd3, "R3 load B");
        apply(1, 4'd3, 1, 8'h00, 3'd7, "R8 overflow keeps S X I");
        // R10 idle and undefined codes
        apply(0, 4'd3, 1, 8'h55, 3'd0, "R10 valid low");
        apply(1, 4'd0, 1, 8'h55, 3'd0, "R10 nop");
        apply(1, 4'd9, 1, 8'h55, 3'd0, "R10 unused code");
        apply(1, 4'd15, 1, 8'h55, 3'd0, "R10 unused code");
        // R9 branch sweep over flag patterns
        for (int p = 0; p < 16; p++) begin
            apply(1, 4'd7, 1, {4'hD, p[3:0]}, 3'd0, "R8 ccr write");
            for (int s = 0; s < 8; s++) begin
                apply(0, 4'd0, 1, 8'h00, s[2:0], "R9 branch");
            end
        end
        @(negedge clk);
        op_valid = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule